// File: doc/BRIEF.md
# GPIO Port with Peripheral Override Mux

An eight-pin general-purpose I/O port. Each pin is normally controlled by software registers. Peripheral alternate functions can take over a pin's direction and pull-up through per-pin override pairs. Each pair is an enable and a value. When an enable is set, its value replaces the register-derived setting for that pin. A global pull-up disable turns off every pull-up that comes from the register path. Only a few override sources can bypass it.

For each pin the block computes four results: output enable, output value, pull-up enable and a synchronized copy of the pad input. Sources are resolved in a fixed priority, with boundary scan first, then overrides, then registers. A transmit-style function forces its pin to drive and holds the pull-up off. A receive-style function keeps the pull-up under software control, but only while the global disable is clear. A debug-enable input turns on the pull-ups of the pins it owns. A boundary-scan takeover gives the scan cells final control of all three pad controls.

A small register bus gives software access to four registers: direction, port data, pin state with toggle-on-write, and control. All override inputs are combinational. The only sequential paths are the registers and the input synchronizer.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction, port data and control registers read 0, and the pad output enable, output value and pull-up outputs are 0.
- R2: For a pin with no active override and no scan, the output enable equals the direction bit (1 = output). The output value equals the port bit. The pull-up is on only when the direction bit is 0 and the port bit is 1, so an output pin never has its pull-up on from the register path.
- R3: While the global pull-up disable (control register address 3, bit 0) is 1, no register-path pull-up is on, whatever the direction and port bits are.
- R4: When a pin's raw pull-up override enable is 1, and no higher source owns the pin, its pull-up equals the pull-up override value. This also holds while the global disable is set.
- R5: When a pin's raw direction override enable is 1, its output enable equals the direction override value instead of the direction bit.
- R6: A pin with its transmit function active is an output, drives the transmit data bit, and has its pull-up off, regardless of the registers.
- R7: A pin with its receive function active has its pull-up equal to (port bit AND NOT global disable). This takes priority over the raw pull-up override.
- R8: While debug enable is 1, every pin in the debug-owned mask (default pins 7..4) has its pull-up on, even with the global disable set. Pins outside the mask are unaffected.
- R9: While boundary-scan takeover is 1, output enable, output value and pull-up equal the scan cell values on every pin, above all other sources.
- R10: The pin register (address 2) and the synchronized-input output return the pad input through two flip-flops. A pad change is visible after the second rising edge and not after the first, in every mode.
- R11: Writing to address 2 inverts each port bit whose written bit is 1 and leaves the other port bits unchanged, in one cycle.
- R12: Writes to address 0 (direction) and address 1 (port data) take effect at the next rising edge and read back unchanged. Address 3 reads the global disable in bit 0 and zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational on address |
| pad_i | input | 8 | Raw pad input levels |
| alt_tx_en_i | input | 8 | Per-pin transmit function active |
| alt_tx_data_i | input | 8 | Per-pin transmit data |
| alt_rx_en_i | input | 8 | Per-pin receive function active |
| dbg_en_i | input | 1 | Debug enable, claims pull-ups of owned pins |
| pu_ovr_en_i | input | 8 | Raw pull-up override enable |
| pu_ovr_val_i | input | 8 | Raw pull-up override value |
| dir_ovr_en_i | input | 8 | Raw direction override enable |
| dir_ovr_val_i | input | 8 | Raw direction override value |
| scan_en_i | input | 1 | Boundary-scan takeover |
| scan_oe_i | input | 8 | Scan cell output enables |
| scan_out_i | input | 8 | Scan cell output values |
| scan_pu_i | input | 8 | Scan cell pull-up enables |
| pad_oe_o | output | 8 | Pad output enable |
| pad_out_o | output | 8 | Pad output value |
| pad_pu_o | output | 8 | Pad pull-up enable |
| pin_sync_o | output | 8 | Synchronized pad input |

## Verification
A wrong direction or port register shows up in two places on the same cycle. The register reads back wrong, and the pad enables of every pin that has no override are wrong too. A wrong priority between sources shows up at once on the pad outputs, because the override mux is purely combinational. Examples are a receive pin that lets a raw override through, or a debug pin that loses to the global disable. A synchronizer with one flop too few or too many shows up as the pin value arriving a cycle early or late.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  typedef enum logic [1:0] {
    REG_DIR  = 2'd0,
    REG_PORT = 2'd1,
    REG_PIN  = 2'd2,
    REG_CTRL = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_PUD_BIT = 0;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] port_o,
  output logic         pud_o
);
  logic [W-1:0] dir_q, port_q;
  logic         pud_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      port_q <= '0;
      pud_q  <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        REG_DIR:  dir_q  <= wdata_i;
        REG_PORT: port_q <= wdata_i;
        REG_PIN:  port_q <= port_q ^ wdata_i; // atomic toggle
        default:  pud_q  <= wdata_i[CTRL_PUD_BIT];
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_DIR:  rdata_o = dir_q;
      REG_PORT: rdata_o = port_q;
      REG_PIN:  rdata_o = pin_i;
      default:  rdata_o[CTRL_PUD_BIT] = pud_q;
    endcase
  end

  assign dir_o  = dir_q;
  assign port_o = port_q;
  assign pud_o  = pud_q;

  p_toggle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_PIN) |=> (port_q == ($past(port_q) ^ $past(wdata_i))));
  p_dir_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_DIR) |=> (dir_q == $past(wdata_i)));
  p_port_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || addr_i == REG_DIR || addr_i == REG_CTRL) |=> $stable(port_q));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // settle counter so the delay check never looks before reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  p_two_flop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && STAGES == 2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_ovr_gen.sv
module gpio_ovr_gen #(
  parameter int unsigned  W        = 8,
  parameter logic [W-1:0] DBG_MASK = 8'hF0
) (
  input  logic [W-1:0] port_i,
  input  logic         pud_i,
  input  logic [W-1:0] tx_en_i,
  input  logic [W-1:0] tx_data_i,
  input  logic [W-1:0] rx_en_i,
  input  logic         dbg_en_i,
  input  logic [W-1:0] pu_en_raw_i,
  input  logic [W-1:0] pu_val_raw_i,
  input  logic [W-1:0] dir_en_raw_i,
  input  logic [W-1:0] dir_val_raw_i,
  output logic [W-1:0] pu_en_o,
  output logic [W-1:0] pu_val_o,
  output logic [W-1:0] dir_en_o,
  output logic [W-1:0] dir_val_o,
  output logic [W-1:0] out_en_o,
  output logic [W-1:0] out_val_o
);
  logic [W-1:0] dbg_own;
  assign dbg_own = dbg_en_i ? DBG_MASK : '0;

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      // pull-up priority: debug, transmit, receive, raw peripheral
      pu_en_o[i] = dbg_own[i] | tx_en_i[i] | rx_en_i[i] | pu_en_raw_i[i];
      if (dbg_own[i])      pu_val_o[i] = 1'b1;
      else if (tx_en_i[i]) pu_val_o[i] = 1'b0;
      else if (rx_en_i[i]) pu_val_o[i] = port_i[i] & ~pud_i;
      else                 pu_val_o[i] = pu_val_raw_i[i];

      dir_en_o[i]  = tx_en_i[i] | dir_en_raw_i[i];
      dir_val_o[i] = tx_en_i[i] ? 1'b1 : dir_val_raw_i[i];

      out_en_o[i]  = tx_en_i[i];
      out_val_o[i] = tx_data_i[i];
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] port_i,
  input  logic         pud_i,
  input  logic [W-1:0] pu_en_i,
  input  logic [W-1:0] pu_val_i,
  input  logic [W-1:0] dir_en_i,
  input  logic [W-1:0] dir_val_i,
  input  logic [W-1:0] out_en_i,
  input  logic [W-1:0] out_val_i,
  input  logic         scan_en_i,
  input  logic [W-1:0] scan_oe_i,
  input  logic [W-1:0] scan_out_i,
  input  logic [W-1:0] scan_pu_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic reg_pu;
    assign reg_pu = ~dir_i[i] & port_i[i] & ~pud_i;

    always_comb begin
      if (scan_en_i) begin
        oe_o[i]  = scan_oe_i[i];
        out_o[i] = scan_out_i[i];
        pu_o[i]  = scan_pu_i[i];
      end else begin
        oe_o[i]  = dir_en_i[i] ? dir_val_i[i] : dir_i[i];
        out_o[i] = out_en_i[i] ? out_val_i[i] : port_i[i];
        pu_o[i]  = pu_en_i[i]  ? pu_val_i[i]  : reg_pu;
      end
    end
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
  parameter int unsigned  W        = 8,
  parameter logic [W-1:0] DBG_MASK = 8'hF0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_we_i,
  input  logic [1:0]   bus_addr_i,
  input  logic [W-1:0] bus_wdata_i,
  output logic [W-1:0] bus_rdata_o,
  input  logic [W-1:0] pad_i,
  input  logic [W-1:0] alt_tx_en_i,
  input  logic [W-1:0] alt_tx_data_i,
  input  logic [W-1:0] alt_rx_en_i,
  input  logic         dbg_en_i,
  input  logic [W-1:0] pu_ovr_en_i,
  input  logic [W-1:0] pu_ovr_val_i,
  input  logic [W-1:0] dir_ovr_en_i,
  input  logic [W-1:0] dir_ovr_val_i,
  input  logic         scan_en_i,
  input  logic [W-1:0] scan_oe_i,
  input  logic [W-1:0] scan_out_i,
  input  logic [W-1:0] scan_pu_i,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_pu_o,
  output logic [W-1:0] pin_sync_o
);
  logic [W-1:0] dir, port, pin_s;
  logic         pud;
  logic [W-1:0] pu_en, pu_val, dir_en, dir_val, out_en, out_val;

  gpio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(pin_s)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .pin_i(pin_s), .rdata_o(bus_rdata_o),
    .dir_o(dir), .port_o(port), .pud_o(pud)
  );

  gpio_ovr_gen #(.W(W), .DBG_MASK(DBG_MASK)) u_ovr (
    .port_i(port), .pud_i(pud),
    .tx_en_i(alt_tx_en_i), .tx_data_i(alt_tx_data_i), .rx_en_i(alt_rx_en_i),
    .dbg_en_i,
    .pu_en_raw_i(pu_ovr_en_i), .pu_val_raw_i(pu_ovr_val_i),
    .dir_en_raw_i(dir_ovr_en_i), .dir_val_raw_i(dir_ovr_val_i),
    .pu_en_o(pu_en), .pu_val_o(pu_val), .dir_en_o(dir_en), .dir_val_o(dir_val),
    .out_en_o(out_en), .out_val_o(out_val)
  );

  gpio_pin_mux #(.W(W)) u_mux (
    .dir_i(dir), .port_i(port), .pud_i(pud),
    .pu_en_i(pu_en), .pu_val_i(pu_val), .dir_en_i(dir_en), .dir_val_i(dir_val),
    .out_en_i(out_en), .out_val_i(out_val),
    .scan_en_i, .scan_oe_i, .scan_out_i, .scan_pu_i,
    .oe_o(pad_oe_o), .out_o(pad_out_o), .pu_o(pad_pu_o)
  );

  assign pin_sync_o = pin_s;

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (dir == '0 && port == '0 && !pud));
  p_no_pu_on_output_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |-> ((pad_oe_o & pad_pu_o & ~pu_en & ~dir_en) == '0));
  p_pud_blocks_reg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pud && !scan_en_i) |-> ((pad_pu_o & ~pu_en) == '0));
  p_tx_forces_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |-> (((alt_tx_en_i & ~DBG_MASK) & (~pad_oe_o | pad_pu_o)) == '0 || dbg_en_i));
  p_rx_pud_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pud && !scan_en_i && !dbg_en_i) |-> ((alt_rx_en_i & ~alt_tx_en_i & pad_pu_o) == '0));
  p_dbg_pu_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_en_i && !scan_en_i) |-> ((DBG_MASK & ~pad_pu_o) == '0));
  p_scan_owns_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |-> (pad_oe_o == scan_oe_i && pad_out_o == scan_out_i && pad_pu_o == scan_pu_i));
endmodule

// File: tb/tb_gpio_ovr_port.sv
module tb_gpio_ovr_port;
  localparam int unsigned W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic         we = 0, dbg = 0, scan = 0;
  logic [1:0]   addr = 0;
  logic [W-1:0] wdata = 0, rdata, pad = 0;
  logic [W-1:0] tx = 0, txd = 0, rx = 0, pue = 0, puv = 0, dre = 0, drv = 0;
  logic [W-1:0] soe = 0, sout = 0, spu = 0;
  logic [W-1:0] oe, pout, pu, psync;

  gpio_ovr_port #(.W(W), .DBG_MASK(8'hF0)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_i(pad), .alt_tx_en_i(tx), .alt_tx_data_i(txd), .alt_rx_en_i(rx),
    .dbg_en_i(dbg), .pu_ovr_en_i(pue), .pu_ovr_val_i(puv),
    .dir_ovr_en_i(dre), .dir_ovr_val_i(drv),
    .scan_en_i(scan), .scan_oe_i(soe), .scan_out_i(sout), .scan_pu_i(spu),
    .pad_oe_o(oe), .pad_out_o(pout), .pad_pu_o(pu), .pin_sync_o(psync)
  );

  int checks = 0, errors = 0;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  typedef struct packed {
    logic [7:0] req;
    logic [W-1:0] dir, port; logic pud;
    logic [W-1:0] tx, txd, rx; logic dbg;
    logic [W-1:0] pue, puv, dre, drv; logic scan;
    logic [W-1:0] soe, sout, spu;
    logic [W-1:0] eoe, eout, epu;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // R2 plain register path
    '{8'd2,  8'h0F,8'hFF,1'b0, 8'h00,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00, 8'h0F,8'hFF,8'hF0},
    // R3 global disable
    '{8'd3,  8'h0F,8'hFF,1'b1, 8'h00,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00, 8'h0F,8'hFF,8'h00},
    // R4 partial raw pull-up override
    '{8'd4,  8'h00,8'hA5,1'b0, 8'h00,8'h00,8'h00,1'b0, 8'h0F,8'h03,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00, 8'h00,8'hA5,8'hA3},
    // R4 raw override beats global disable
    '{8'd4,  8'h00,8'h00,1'b1, 8'h00,8'h00,8'h00,1'b0, 8'hFF,8'h3C,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00, 8'h00,8'h00,8'h3C},
    // R5 direction override
    '{8'd5,  8'hF0,8'h00,1'b0, 8'h00,8'h00,8'h00,1'b0, 8'h00,8'h00,8'hFF,8'h0F,1'b0, 8'h00,8'h00,8'h00, 8'h0F,8'h00,8'h00},
    // R6 transmit, data 1, pull-up forced off
    '{8'd6,  8'h00,8'hFF,1'b0, 8'h01,8'h01,8'h00,1'b0, 8'h00,8'h00,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00, 8'h01,8'hFF,8'hFE},
    // R6 transmit, data 0 despite port 1
    '{8'd6,  8'h00,8'h02,1'b0, 8'h02,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00, 8'h02,8'h00,8'h00},
    // R7 receive under disable beats raw override
    '{8'd7,  8'h00,8'h01,1'b1, 8'h00,8'h00,8'h01,1'b0, 8'h01,8'h01,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00, 8'h00,8'h01,8'h00},
    // R7 receive follows port with disable clear
    '{8'd7,  8'h01,8'h01,1'b0, 8'h00,8'h00,8'h01,1'b0, 8'h00,8'h00,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00, 8'h01,8'h01,8'h01},
    // R8 debug pull-ups despite disable
    '{8'd8,  8'h00,8'h00,1'b1, 8'h00,8'h00,8'h00,1'b1, 8'h00,8'h00,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00, 8'h00,8'h00,8'hF0},
    // R9 scan over everything
    '{8'd9,  8'hFF,8'hFF,1'b0, 8'hFF,8'h00,8'h00,1'b1, 8'hFF,8'hFF,8'hFF,8'hFF,1'b1, 8'hAA,8'h55,8'h0F, 8'hAA,8'h55,8'h0F},
    // R2 mixed direction
    '{8'd2,  8'h3C,8'hF0,1'b0, 8'h00,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00,8'h00,1'b0, 8'h00,8'h00,8'h00, 8'h3C,8'hF0,8'hC0}
  };

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2'd0, r); check("R1 dir", r, 8'h00);
    rd(2'd1, r); check("R1 port", r, 8'h00);
    rd(2'd3, r); check("R1 ctrl", r, 8'h00);
    check("R1 oe", oe, 8'h00); check("R1 out", pout, 8'h00); check("R1 pu", pu, 8'h00);

    for (int v = 0; v < NV; v++) begin
      string tag;
      wr(2'd0, VEC[v].dir); wr(2'd1, VEC[v].port); wr(2'd3, {7'b0, VEC[v].pud});
      @(negedge clk);
      tx = VEC[v].tx; txd = VEC[v].txd; rx = VEC[v].rx; dbg = VEC[v].dbg;
      pue = VEC[v].pue; puv = VEC[v].puv; dre = VEC[v].dre; drv = VEC[v].drv;
      scan = VEC[v].scan; soe = VEC[v].soe; sout = VEC[v].sout; spu = VEC[v].spu;
      #1;
      tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
      check({tag, " oe"}, oe, VEC[v].eoe);
      check({tag, " out"}, pout, VEC[v].eout);
      check({tag, " pu"}, pu, VEC[v].epu);
    end
    tx = 0; rx = 0; dbg = 0; pue = 0; dre = 0; scan = 0;

    // R12 readback and control layout
    wr(2'd0, 8'h96); rd(2'd0, r); check("R12 dir readback", r, 8'h96);
    wr(2'd1, 8'h0F); rd(2'd1, r); check("R12 port readback", r, 8'h0F);
    wr(2'd3, 8'hFF); rd(2'd3, r); check("R12 ctrl only bit0", r, 8'h01);
    wr(2'd3, 8'h00);

    // R11 toggle
    wr(2'd2, 8'h3C); rd(2'd1, r); check("R11 toggle", r, 8'h33);
    wr(2'd2, 8'h00); rd(2'd1, r); check("R11 zero toggle", r, 8'h33);

    // R10 two-flop sync, also under scan
    scan = 1;
    @(negedge clk); pad = 8'h5A;
    @(negedge clk); addr = 2'd2; #1 check("R10 after one edge", psync, 8'h00);
    @(negedge clk); #1 check("R10 after two edges", psync, 8'h5A);
    check("R10 pin register", rdata, 8'h5A);
    scan = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule